// File: doc/BRIEF.md
# Bi-Endian Sub-Word Bus Aligner

This block joins a 32-bit processor load/store port to a 32-bit memory bus whose byte lanes are wired little-endian. Each request carries an access size (byte, half-word or word), a read/write flag, a signed/unsigned flag and a byte address. For a store, the block copies the data onto every lane and raises the byte enables of the lanes that the addressed bytes occupy. For a load, it takes the word returned by the bus in the same cycle, picks out the addressed byte or half-word, moves it to bit 0, and zero- or sign-extends it. The result appears one cycle after the request.

A one-bit endian mode register sets how byte offsets map to lanes. Word accesses do not depend on the mode, so a word written in one mode reads back the same in the other. Byte and half-word accesses use mirrored lanes in big-endian mode.

Software writes the mode register through a dedicated strobe. Reset clears it, which selects little-endian. A misaligned request never reaches the bus. It raises a one-cycle error flag, and a load that is misaligned returns zero.

Top module: `bus_lane_aligner`

## Requirements
- R1: After reset the mode is little-endian (`bigEndian`=0), and with no request pending `busValid`, `rspValid` and `misalignErr` are all low.
- R2: In little-endian mode a byte at address offset k (k = reqAddr[1:0]) uses lane k, which is bits 8k+7:8k. Its byte enable is bit k of `busByteEn`.
- R3: In big-endian mode a byte at offset k uses lane 3-k. A word stored in one mode therefore reads back as bytes in the reverse order after the mode is switched.
- R4: A half-word at offset 0 uses bits 15:0 in little-endian mode and bits 31:16 in big-endian mode. At offset 2 the two are swapped. Both bytes keep their word order, so word 0xBBCCDDEE read at offset 0 gives 0xDDEE (little) or 0xBBCC (big).
- R5: Size code 2 (word) at offset 0 passes the full word in both modes. A word store raises all four enables, and a word load returns the bus word unchanged.
- R6: A store puts the byte on all four lanes or the half-word on both halves of `busWdata`, raises `busValid` and `busWrite`, and enables only the addressed lanes.
- R7: A load with `reqSigned`=1 sign-extends a byte or half-word result to 32 bits. With `reqSigned`=0 the upper bits are zero.
- R8: Any of the following is an error: a half-word (size 1) with reqAddr[0]=1, a word (size 2) with reqAddr[1:0]≠0, or size code 3. For an error request `busValid` is low and `busByteEn` is 0. In the next cycle `misalignErr` is high for one cycle, and for a load `rspData` is 0.
- R9: A pulse on `ctrlWrEn` loads `ctrlWrData` into the mode bit. A request issued in the same cycle as the write still uses the old mode, and the new mode applies from the next cycle.
- R10: Size codes are 0 byte, 1 half-word, 2 word. Every load request, including an error load, gives `rspValid` exactly one cycle later. `busRdata` is sampled in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Write strobe for the endian mode bit |
| ctrlWrData | input | 1 | New mode value: 1 = big-endian |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqSize | input | 2 | 0 byte, 1 half-word, 2 word, 3 invalid |
| reqSigned | input | 1 | Sign-extend sub-word load results |
| reqAddr | input | ADDR_W | Byte address of the access |
| reqWdata | input | 32 | Store data, right-justified |
| busValid | output | 1 | Bus access issued this cycle |
| busWrite | output | 1 | Bus access is a write |
| busAddr | output | ADDR_W | Word-aligned bus address |
| busByteEn | output | 4 | Byte-lane enables |
| busWdata | output | 32 | Lane-steered store data |
| busRdata | input | 32 | Read word returned by the bus in the request cycle |
| rspValid | output | 1 | Load result valid |
| rspData | output | 32 | Extended load result |
| misalignErr | output | 1 | One-cycle error pulse for an illegal request |
| bigEndian | output | 1 | Current endian mode |

## Verification
The hardest case to reach is a mode write and an access landing in the same cycle, because only then does it matter whether the mode register updates before or after the lane decode. The stimulus issues a byte load in the very cycle that sets big-endian mode and expects the little-endian byte. The next access reads the same address and expects the mirrored byte. A second case writes a word in one mode, flips the mode, and reads it back as bytes, expecting the reversed order.

// File: rtl/align_pkg.sv
package align_pkg;

  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int OFFS_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_e;

  // Strobes passed from the control decode to the datapath.
  typedef struct packed {
    logic              issue;    // aligned access goes to the bus
    logic              store;    // issued access is a write
    logic              load;     // any load request (aligned or not)
    logic              misalign; // illegal request this cycle
    accSize_e          size;
    logic              sext;
    logic [OFFS_W-1:0] lane;     // lowest lane the access touches
    logic [LANES-1:0]  byteEn;
  } ctrlStrobes_t;

endpackage

// File: rtl/align_ctrl.sv
module align_ctrl
  import align_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic              ctrlWrData,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic              reqSigned,
  input  logic [OFFS_W-1:0] reqOffs,
  output ctrlStrobes_t      strb,
  output logic              bigEndian
);

  logic              modeQ;
  accSize_e          sizeE;
  logic              badAlign;
  logic [OFFS_W-1:0] flipMask;
  logic [OFFS_W-1:0] laneSel;
  logic [LANES-1:0]  enBits;
  logic              issueOk;

  // Endian mode register: the write lands at the edge, so the request
  // presented in the same cycle still decodes with the old value.
  always_ff @(posedge clk) begin
    if (!rstN)         modeQ <= 1'b0;
    else if (ctrlWrEn) modeQ <= ctrlWrData;
  end

  assign bigEndian = modeQ;
  assign sizeE     = accSize_e'(reqSize);

  always_comb begin
    unique case (sizeE)
      SZ_BYTE: badAlign = 1'b0;
      SZ_HALF: badAlign = reqOffs[0];
      SZ_WORD: badAlign = |reqOffs;
      default: badAlign = 1'b1;
    endcase
  end

  // Big-endian mirrors the offset inside the word at the access granule.
  always_comb begin
    flipMask = '0;
    if (modeQ) begin
      unique case (sizeE)
        SZ_BYTE: flipMask = OFFS_W'(LANES - 1);
        SZ_HALF: flipMask = OFFS_W'(LANES - 2);
        default: flipMask = '0;
      endcase
    end
    laneSel = reqOffs ^ flipMask;
  end

  assign issueOk = reqValid & ~badAlign;

  for (genvar i = 0; i < LANES; i++) begin : g_lane_en
    localparam logic [OFFS_W-1:0] LANE_I = OFFS_W'(i);
    logic hit;
    always_comb begin
      unique case (sizeE)
        SZ_BYTE: hit = (laneSel == LANE_I);
        SZ_HALF: hit = (laneSel[OFFS_W-1] == LANE_I[OFFS_W-1]);
        default: hit = 1'b1;
      endcase
    end
    assign enBits[i] = issueOk & hit;
  end

  always_comb begin
    strb.issue    = issueOk;
    strb.store    = issueOk & reqWrite;
    strb.load     = reqValid & ~reqWrite;
    strb.misalign = reqValid & badAlign;
    strb.size     = sizeE;
    strb.sext     = reqSigned;
    strb.lane     = laneSel;
    strb.byteEn   = enBits;
  end

endmodule

// File: rtl/align_datapath.sv
module align_datapath
  import align_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic              busValid,
  output logic              busWrite,
  output logic [LANES-1:0]  busByteEn,
  output logic [DATA_W-1:0] busWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              misalignErr
);

  localparam int HALF_W = 16;

  logic [DATA_W-1:0] laneShifted;
  logic [DATA_W-1:0] loadExt;

  assign busValid  = strb.issue;
  assign busWrite  = strb.store;
  assign busByteEn = strb.byteEn;

  // Store steering: copy the datum onto every lane it could occupy.
  for (genvar i = 0; i < LANES; i++) begin : g_wlane
    always_comb begin
      unique case (strb.size)
        SZ_BYTE: busWdata[i*8 +: 8] = reqWdata[7:0];
        SZ_HALF: busWdata[i*8 +: 8] = reqWdata[(i % 2)*8 +: 8];
        default: busWdata[i*8 +: 8] = reqWdata[i*8 +: 8];
      endcase
    end
  end

  // Load extraction: shift the addressed lane down to bit 0 and extend.
  assign laneShifted = busRdata >> {strb.lane, 3'b000};

  always_comb begin
    unique case (strb.size)
      SZ_BYTE: loadExt = strb.sext
                   ? {{(DATA_W-8){laneShifted[7]}}, laneShifted[7:0]}
                   : {{(DATA_W-8){1'b0}}, laneShifted[7:0]};
      SZ_HALF: loadExt = strb.sext
                   ? {{(DATA_W-HALF_W){laneShifted[HALF_W-1]}}, laneShifted[HALF_W-1:0]}
                   : {{(DATA_W-HALF_W){1'b0}}, laneShifted[HALF_W-1:0]};
      default: loadExt = busRdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspData     <= '0;
      misalignErr <= 1'b0;
    end else begin
      rspValid    <= strb.load;
      misalignErr <= strb.misalign;
      if (strb.load) rspData <= strb.misalign ? '0 : loadExt;
    end
  end

endmodule

// File: rtl/bus_lane_aligner.sv
module bus_lane_aligner
  import align_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic              ctrlWrData,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic              reqSigned,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              busValid,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [3:0]        busByteEn,
  output logic [31:0]       busWdata,
  input  logic [31:0]       busRdata,
  output logic              rspValid,
  output logic [31:0]       rspData,
  output logic              misalignErr,
  output logic              bigEndian
);

  ctrlStrobes_t strb;

  assign busAddr = {reqAddr[ADDR_W-1:OFFS_W], {OFFS_W{1'b0}}};

  align_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlWrEn   (ctrlWrEn),
    .ctrlWrData (ctrlWrData),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqSize    (reqSize),
    .reqSigned  (reqSigned),
    .reqOffs    (reqAddr[OFFS_W-1:0]),
    .strb       (strb),
    .bigEndian  (bigEndian)
  );

  align_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reqWdata    (reqWdata),
    .busRdata    (busRdata),
    .busValid    (busValid),
    .busWrite    (busWrite),
    .busByteEn   (busByteEn),
    .busWdata    (busWdata),
    .rspValid    (rspValid),
    .rspData     (rspData),
    .misalignErr (misalignErr)
  );

endmodule

// File: rtl/bus_lane_aligner_checker.sv
module bus_lane_aligner_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctrlWrEn,
  input logic              ctrlWrData,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [1:0]        reqSize,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [31:0]       busRdata,
  input logic              busValid,
  input logic [3:0]        busByteEn,
  input logic              rspValid,
  input logic [31:0]       rspData,
  input logic              misalignErr,
  input logic              bigEndian
);

  logic illegalReq;
  assign illegalReq = reqValid &&
                      ((reqSize == 2'd1 && reqAddr[0]) ||
                       (reqSize == 2'd2 && reqAddr[1:0] != 2'b00) ||
                       (reqSize == 2'd3));

  assert_le_byte_lane_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqSize == 2'd0 && !bigEndian |-> busByteEn == (4'b0001 << reqAddr[1:0]));

  assert_be_byte_lane_R3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqSize == 2'd0 && bigEndian |-> busByteEn == (4'b1000 >> reqAddr[1:0]));

  assert_half_lane_pair_R4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqSize == 2'd1 && !reqAddr[0] |->
      busByteEn == ((reqAddr[1] ^ bigEndian) ? 4'b1100 : 4'b0011));

  assert_word_all_lanes_R5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqSize == 2'd2 && reqAddr[1:0] == 2'b00 |-> busByteEn == 4'hF && busValid);

  assert_word_load_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqWrite && reqSize == 2'd2 && reqAddr[1:0] == 2'b00 |=>
      rspData == $past(busRdata));

  assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    illegalReq |-> !busValid && busByteEn == 4'b0000);

  assert_illegal_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    illegalReq |=> misalignErr);

  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    !illegalReq |=> !misalignErr);

  assert_err_zero_data_R8: assert property (@(posedge clk) disable iff (!rstN)
    misalignErr && rspValid |-> rspData == 32'h0);

  assert_mode_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrEn |=> bigEndian == $past(ctrlWrData));

  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWrEn |=> $stable(bigEndian));

  assert_load_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqWrite |=> rspValid);

  assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !reqWrite) |=> !rspValid);

endmodule

bind bus_lane_aligner bus_lane_aligner_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .ctrlWrEn    (ctrlWrEn),
  .ctrlWrData  (ctrlWrData),
  .reqValid    (reqValid),
  .reqWrite    (reqWrite),
  .reqSize     (reqSize),
  .reqAddr     (reqAddr),
  .busRdata    (busRdata),
  .busValid    (busValid),
  .busByteEn   (busByteEn),
  .rspValid    (rspValid),
  .rspData     (rspData),
  .misalignErr (misalignErr),
  .bigEndian   (bigEndian)
);

// File: tb/bus_lane_aligner_tb.sv
module bus_lane_aligner_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWrEn = 1'b0;
  logic        ctrlWrData = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic        reqSigned = 1'b0;
  logic [31:0] reqAddr = 32'h0;
  logic [31:0] reqWdata = 32'h0;
  logic        busValid, busWrite;
  logic [31:0] busAddr;
  logic [3:0]  busByteEn;
  logic [31:0] busWdata, busRdata;
  logic        rspValid;
  logic [31:0] rspData;
  logic        misalignErr, bigEndian;

  always #2 clk = ~clk;  // 250 MHz

  bus_lane_aligner u_dut (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqSize(reqSize),
    .reqSigned(reqSigned), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busByteEn(busByteEn), .busWdata(busWdata), .busRdata(busRdata),
    .rspValid(rspValid), .rspData(rspData), .misalignErr(misalignErr),
    .bigEndian(bigEndian)
  );

  // Bus memory: 16 words, combinational read, byte-enabled write.
  logic [31:0] mem [16];
  assign busRdata = mem[busAddr[5:2]];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) mem[i] <= 32'h0;
    end else if (busValid && busWrite) begin
      for (int i = 0; i < 4; i++)
        if (busByteEn[i]) mem[busAddr[5:2]][i*8 +: 8] <= busWdata[i*8 +: 8];
    end
  end

  int checks = 0;
  int fails  = 0;
  logic mdlBig = 1'b0;
  logic [31:0] refMem [16];
  bit done = 1'b0;

  typedef struct {
    logic        isLoad;
    logic        err;
    logic [31:0] data;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic bit isIllegal(input logic [1:0] sz, input logic [1:0] off);
    return (sz == 2'd3) || (sz == 2'd1 && off[0]) || (sz == 2'd2 && off != 2'b00);
  endfunction

  function automatic logic [3:0] expEn(input logic [1:0] sz, input logic [1:0] off, input logic be);
    if (isIllegal(sz, off)) return 4'b0000;
    if (sz == 2'd0) return be ? (4'b1000 >> off) : (4'b0001 << off);
    if (sz == 2'd1) return (off[1] ^ be) ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] expLoad(input logic [31:0] w, input logic [1:0] sz,
                                          input logic sg, input logic [1:0] off, input logic be);
    logic [7:0]  b;
    logic [15:0] h;
    if (isIllegal(sz, off)) return 32'h0;
    if (sz == 2'd0) begin
      b = w[(be ? 3 - off : off)*8 +: 8];
      return sg ? {{24{b[7]}}, b} : {24'h0, b};
    end
    if (sz == 2'd1) begin
      h = w[(off[1] ^ be) ? 31 : 15 -: 16];
      return sg ? {{16{h[15]}}, h} : {16'h0, h};
    end
    return w;
  endfunction

  // Driver: one request per cycle; optional mode write in the same cycle.
  task automatic access(input bit wr, input logic [1:0] sz, input bit sg,
                        input logic [31:0] addr, input logic [31:0] wd,
                        input bit modeWr, input bit modeVal, input string tag);
    logic [3:0] en;
    expItem_t it;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqSize = sz; reqSigned = sg;
    reqAddr = addr; reqWdata = wd; ctrlWrEn = modeWr; ctrlWrData = modeVal;
    #1;
    en = expEn(sz, addr[1:0], mdlBig);
    check(busByteEn == en, {tag, " byte enables"}, {28'h0, busByteEn}, {28'h0, en});
    if (wr && !isIllegal(sz, addr[1:0])) begin
      logic [31:0] rep;
      rep = (sz == 2'd0) ? {4{wd[7:0]}} : (sz == 2'd1) ? {2{wd[15:0]}} : wd;
      check(busWdata == rep && busWrite && busValid, {tag, " store lanes"}, busWdata, rep);
      for (int i = 0; i < 4; i++)
        if (en[i]) refMem[addr[5:2]][i*8 +: 8] = rep[i*8 +: 8];
    end
    if (!wr || isIllegal(sz, addr[1:0])) begin
      it.isLoad = !wr;
      it.err    = isIllegal(sz, addr[1:0]);
      it.data   = expLoad(refMem[addr[5:2]], sz, sg, addr[1:0], mdlBig);
      it.tag    = tag;
      expQ.push_back(it);
    end
    if (modeWr) mdlBig = modeVal;
  endtask

  task automatic setMode(input bit v);
    @(negedge clk);
    reqValid = 1'b0; ctrlWrEn = 1'b1; ctrlWrData = v;
    mdlBig = v;
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0; ctrlWrEn = 1'b0;
  endtask

  // Monitor: compare each registered response against the queue head.
  always @(negedge clk) begin
    if (rstN && (rspValid || misalignErr)) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10 unexpected response", rspData, 32'h0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(rspValid == it.isLoad, {it.tag, " rspValid R10"}, {31'h0, rspValid}, {31'h0, it.isLoad});
        check(misalignErr == it.err, {it.tag, " error flag R8"}, {31'h0, misalignErr}, {31'h0, it.err});
        if (it.isLoad)
          check(rspData == it.data, {it.tag, " load data"}, rspData, it.data);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) refMem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(bigEndian == 1'b0, "R1 reset mode", {31'h0, bigEndian}, 32'h0);
    check(!busValid && !rspValid && !misalignErr, "R1 idle outputs",
          {29'h0, busValid, rspValid, misalignErr}, 32'h0);

    // Little-endian basics
    access(1, 2'd2, 0, 32'h10, 32'hBBCCDDEE, 0, 0, "R5 LE word store");
    access(0, 2'd2, 0, 32'h10, 0, 0, 0, "R5 LE word load");
    access(0, 2'd1, 0, 32'h10, 0, 0, 0, "R4 LE half off0");
    access(0, 2'd1, 0, 32'h12, 0, 0, 0, "R4 LE half off2");
    for (int k = 0; k < 4; k++)
      access(0, 2'd0, 0, 32'h10 + k, 0, 0, 0, "R2 LE byte");
    access(0, 2'd1, 1, 32'h10, 0, 0, 0, "R7 LE signed half");

    // Mode write in the same cycle as a load: old mode applies
    access(0, 2'd0, 0, 32'h10, 0, 1, 1, "R9 same-cycle old mode");
    access(0, 2'd0, 0, 32'h10, 0, 0, 0, "R9 next-cycle new mode");
    for (int k = 1; k < 4; k++)
      access(0, 2'd0, 0, 32'h10 + k, 0, 0, 0, "R3 BE byte");
    access(0, 2'd1, 0, 32'h10, 0, 0, 0, "R4 BE half off0");
    access(0, 2'd1, 1, 32'h12, 0, 0, 0, "R4 R7 BE signed half off2");
    access(0, 2'd2, 0, 32'h10, 0, 0, 0, "R5 BE word load");
    access(0, 2'd0, 1, 32'h10, 0, 0, 0, "R7 BE signed byte");
    access(0, 2'd0, 0, 32'h10, 0, 0, 0, "R7 BE unsigned byte");

    // Big-endian stores
    access(1, 2'd0, 0, 32'h15, 32'h0000005A, 0, 0, "R6 BE byte store");
    access(0, 2'd2, 0, 32'h14, 0, 0, 0, "R6 BE byte store readback");
    access(1, 2'd1, 0, 32'h18, 32'h00001234, 0, 0, "R6 BE half store");
    access(0, 2'd2, 0, 32'h18, 0, 0, 0, "R6 BE half store readback");

    // Illegal requests
    access(0, 2'd1, 0, 32'h11, 0, 0, 0, "R8 odd half load");
    access(0, 2'd2, 0, 32'h12, 0, 0, 0, "R8 unaligned word load");
    access(1, 2'd2, 0, 32'h13, 32'hDEADBEEF, 0, 0, "R8 unaligned word store");
    access(0, 2'd3, 0, 32'h10, 0, 0, 0, "R8 reserved size");
    access(0, 2'd2, 0, 32'h10, 0, 0, 0, "R8 memory untouched");

    // Cross-mode: word stored little-endian, read back as bytes in big-endian
    setMode(1'b0);
    access(1, 2'd2, 0, 32'h20, 32'h03020100, 0, 0, "R5 LE word store 2");
    access(1, 2'd1, 0, 32'h1E, 32'h0000A55A, 0, 0, "R6 LE half store off2");
    setMode(1'b1);
    for (int k = 0; k < 4; k++)
      access(0, 2'd0, 0, 32'h20 + k, 0, 0, 0, "R3 reversed bytes");
    access(0, 2'd2, 0, 32'h20, 0, 0, 0, "R5 mode-invariant word");
    access(0, 2'd2, 0, 32'h1C, 0, 0, 0, "R6 LE half store readback");

    idle();
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R10 all responses seen", expQ.size(), 32'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule